// File: doc/BRIEF.md
# Video Decoder Control Register Interface

This block is the serial control port of a multistandard video decoder. It is a two-wire (I2C) slave, oversampled by the system clock, that holds the decoder's write-only control settings and returns one read-only status byte. The bus pins follow the open-drain model: the block never drives SDA high. It only asserts `sda_pull_low` when it needs the line low, and it reads the wired level back on `sda_i`.

A write transaction carries the device address, then a subaddress byte, then any number of data bytes. The subaddress steps by one after every data byte. The stored fields leave the block as parallel control signals. A read transaction returns the status byte, and it returns the same byte again for as long as the master acknowledges. One strap input selects between two device addresses.

The block also orders start-up. A power-on flag is set by reset and is visible in the status byte. A line-oscillator calibration request is issued on a write to subaddress 0x01, but only once subaddress 0x00, which carries the crystal configuration, has been written since reset.

Top module: `vdec_ctl_i2c`

## Requirements
- R1: The 8-bit write address is 0x8A with `addr_strap` low and 0x8E with it high. Bit 0 of the address byte is the read/write flag, where 1 means read. A matching address is acknowledged. Any other address is not acknowledged, and the block leaves SDA released for every following byte until the next START.
- R2: Only the low 4 bits of the subaddress byte are kept, giving subaddresses 0x00 to 0x0F. After each data byte the subaddress increments modulo 16, so the byte after 0x0F lands in 0x00.
- R3: Subaddress 0x00 fields, from bit 7 down: `src_sel` [7:6], `trap_bypass` [5], `comb_en` [4], `p1_tc_sel` [3:2], `xtal_cfg` [1:0].
- R4: Subaddress 0x01 fields, from bit 7 down: `field_force` [7:6], `ioport_out` [5], `oport_out` [4], `p1_open` [3], `std_force` [2], `secam_force` [1], `xtal_force` [0].
- R5: Subaddress 0x02 holds `fsw_en` [7], `search_tune` [6] and `hue` [5:0]. Subaddress 0x03 holds only `llc_mode` in bit 7, and bits 6:0 of that byte are ignored.
- R6: Data bytes written to subaddresses 0x04 to 0x0F are acknowledged, and no control output changes.
- R7: The status byte, from bit 7 down, is: power-on flag, `fld60_in`, `yc_in`, `p1_lock_in`, `ioport_pin_in`, `std_code_in` [2:0]. The standard code values are: 000 PAL on the second crystal, 001 PAL on the reference crystal, 010 NTSC on the second crystal, 011 NTSC on the reference crystal, 100 illegal forced mode, 101 SECAM, 11x colour off. The code is passed through unchanged.
- R8: The power-on flag reads 1 after reset. It clears once the first status byte has been fully read, at the master's acknowledge clock.
- R9: When the master acknowledges a status byte, the block returns the status byte again. A not-acknowledge ends the read, and SDA stays released.
- R10: `cal_req` is a one-cycle pulse, issued once per data byte written to subaddress 0x01, and only if subaddress 0x00 has been written since reset.
- R11: Out of reset, every control output is 0, `cal_req` is 0 and SDA is released.
- R12: `sda_pull_low` only ever asserts while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 1 | Selects the device address (0x8A or 0x8E) |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired) |
| sda_pull_low | output | 1 | 1 pulls SDA low; 0 releases the line |
| src_sel | output | 2 | Input source select |
| trap_bypass | output | 1 | Chroma notch bypass |
| comb_en | output | 1 | Comb filter enable |
| p1_tc_sel | output | 2 | Phase-1 loop time-constant select |
| xtal_cfg | output | 2 | Crystal configuration |
| field_force | output | 2 | Forced field frequency |
| ioport_out | output | 1 | I/O port output value |
| oport_out | output | 1 | Output port value |
| p1_open | output | 1 | Phase-1 loop open |
| std_force | output | 1 | Forced-standard mode |
| secam_force | output | 1 | SECAM force |
| xtal_force | output | 1 | Crystal force |
| fsw_en | output | 1 | Fast switch enable |
| search_tune | output | 1 | Search-tuning mode |
| hue | output | 6 | Hue setting |
| llc_mode | output | 1 | 1 selects line-locked clock/HA mode; 0 selects port/clamp mode |
| cal_req | output | 1 | Line-oscillator calibration request pulse |
| fld60_in | input | 1 | Field frequency indication (1 = 60 Hz) |
| yc_in | input | 1 | Y/C input mode indication |
| p1_lock_in | input | 1 | Phase-1 lock indication |
| ioport_pin_in | input | 1 | I/O port pin level |
| std_code_in | input | 3 | Standard readout code |

## Verification
The assertions assume a well-formed bus:
- SCL and SDA each hold steady for several system clocks at a time, which outlasts the synchronizer latency.
- SDA changes while SCL is high only to form a START or STOP.
- Writes arrive no faster than one byte time apart.
- The master not-acknowledges the last byte of a read before it issues a STOP.

The bench keeps within these assumptions. It generates every bus phase in quarter-bit steps of six clocks, and it ends every read with a not-acknowledge. Only wrong addresses, subaddress wrap-around, writes to unimplemented subaddresses and out-of-order start-up writes are exercised as corner cases.

// File: rtl/vdec_ctl_pkg.sv
package vdec_ctl_pkg;

  localparam int SUB_W    = 4;
  localparam int NUM_REGS = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_SUB,
    ST_ACK_S,
    ST_WR,
    ST_ACK_W,
    ST_RD,
    ST_RACK,
    ST_RNEXT,
    ST_IGNORE
  } i2c_st_e;

  typedef struct packed {
    logic [1:0] src;
    logic       trap;
    logic       comb;
    logic [1:0] tc;
    logic [1:0] xtal;
  } ctl0_t;

  typedef struct packed {
    logic [1:0] fforce;
    logic       iop;
    logic       op;
    logic       open;
    logic       stdf;
    logic       secam;
    logic       xforce;
  } ctl1_t;

  typedef struct packed {
    logic       fsw;
    logic       stm;
    logic [5:0] hue;
  } ctl2_t;

endpackage

// File: rtl/vdec_i2c_sync.sv
module vdec_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_sh, sda_sh;
  logic [DEPTH-1:0] scl_sh_n, sda_sh_n;
  logic             scl_prev, sda_prev;

  assign scl_sh_n = {scl_sh[DEPTH-2:0], scl_i};
  assign sda_sh_n = {sda_sh[DEPTH-2:0], sda_i};

  // Idle bus is high, so the chain resets high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= scl_sh_n;
      sda_sh <= sda_sh_n;
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_prev  = scl_sh[STAGES];
  assign sda_prev  = sda_sh[STAGES];

  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/vdec_i2c_engine.sv
module vdec_i2c_engine
  import vdec_ctl_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b10001,
  parameter logic       ADDR_LO = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       status_byte,
  output logic             sda_drive_low,
  output logic             wr_en,
  output logic [SUB_W-1:0] wr_sub,
  output logic [7:0]       wr_data,
  output logic             rd_done
);

  localparam logic [3:0] BYTE_BITS = 4'd8;
  localparam logic [3:0] LAST_TX   = 4'd7;

  i2c_st_e          st, st_n;
  logic [3:0]       cnt, cnt_n;
  logic [7:0]       sh, sh_n;
  logic [SUB_W-1:0] sub, sub_n;
  logic             drv, drv_n;
  logic             rw, rw_n;
  logic             wr_en_n, rd_done_n;
  logic [SUB_W-1:0] wr_sub_n;
  logic [7:0]       wr_data_n;
  logic [6:0]       dev_addr;

  assign dev_addr = {ADDR_HI, strap, ADDR_LO};

  always_comb begin
    st_n      = st;
    cnt_n     = cnt;
    sh_n      = sh;
    sub_n     = sub;
    drv_n     = drv;
    rw_n      = rw;
    wr_en_n   = 1'b0;
    wr_sub_n  = wr_sub;
    wr_data_n = wr_data;
    rd_done_n = 1'b0;
    if (stop_det) begin
      st_n  = ST_IDLE;
      drv_n = 1'b0;
    end else if (start_det) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      drv_n = 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_SUB, ST_WR: begin
          if (scl_rise && cnt < BYTE_BITS) begin
            sh_n  = {sh[6:0], sda_lvl};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == BYTE_BITS) begin
            if (st == ST_ADDR) begin
              if (sh[7:1] == dev_addr) begin
                drv_n = 1'b1;
                rw_n  = sh[0];
                st_n  = ST_ACK_A;
              end else begin
                st_n  = ST_IGNORE;
              end
            end else if (st == ST_SUB) begin
              sub_n = sh[SUB_W-1:0];
              drv_n = 1'b1;
              st_n  = ST_ACK_S;
            end else begin
              wr_en_n   = 1'b1;
              wr_sub_n  = sub;
              wr_data_n = sh;
              sub_n     = sub + 1'b1;
              drv_n     = 1'b1;
              st_n      = ST_ACK_W;
            end
          end
        end
        ST_ACK_A: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw) begin
              sh_n  = status_byte;
              drv_n = ~status_byte[7];
              st_n  = ST_RD;
            end else begin
              drv_n = 1'b0;
              st_n  = ST_SUB;
            end
          end
        end
        ST_ACK_S, ST_ACK_W: begin
          if (scl_fall) begin
            drv_n = 1'b0;
            cnt_n = '0;
            st_n  = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt == LAST_TX) begin
              drv_n = 1'b0;
              st_n  = ST_RACK;
            end else begin
              sh_n  = {sh[6:0], 1'b0};
              drv_n = ~sh[6];
              cnt_n = cnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            rd_done_n = 1'b1;
            st_n      = sda_lvl ? ST_IGNORE : ST_RNEXT;
          end
        end
        ST_RNEXT: begin
          if (scl_fall) begin
            sh_n  = status_byte;
            drv_n = ~status_byte[7];
            cnt_n = '0;
            st_n  = ST_RD;
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      sub     <= '0;
      drv     <= 1'b0;
      rw      <= 1'b0;
      wr_en   <= 1'b0;
      wr_sub  <= '0;
      wr_data <= '0;
      rd_done <= 1'b0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      sh      <= sh_n;
      sub     <= sub_n;
      drv     <= drv_n;
      rw      <= rw_n;
      wr_en   <= wr_en_n;
      wr_sub  <= wr_sub_n;
      wr_data <= wr_data_n;
      rd_done <= rd_done_n;
    end
  end

  assign sda_drive_low = drv;

  assert_pull_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_lvl);

  assert_ignore_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |-> !sda_drive_low);

  assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

endmodule

// File: rtl/vdec_regbank.sv
module vdec_regbank
  import vdec_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SUB_W-1:0] wr_sub,
  input  logic [7:0]       wr_data,
  input  logic             rd_done,
  input  logic [6:0]       live_status,
  output ctl0_t            r0,
  output ctl1_t            r1,
  output ctl2_t            r2,
  output logic             r3_llc,
  output logic             cal_req,
  output logic [7:0]       status_byte
);

  localparam logic [SUB_W-1:0] SUB_XTAL  = SUB_W'(0);
  localparam logic [SUB_W-1:0] SUB_CAL   = SUB_W'(1);
  localparam logic [SUB_W-1:0] SUB_VID   = SUB_W'(2);
  localparam logic [SUB_W-1:0] SUB_MODE  = SUB_W'(3);
  localparam logic [SUB_W-1:0] LAST_IMPL = SUB_W'(NUM_REGS - 1);

  ctl0_t r0_n;
  ctl1_t r1_n;
  ctl2_t r2_n;
  logic  r3_n;
  logic  xtal_seen, xtal_seen_n;
  logic  cal_n;
  logic  por, por_n;

  always_comb begin
    r0_n        = r0;
    r1_n        = r1;
    r2_n        = r2;
    r3_n        = r3_llc;
    xtal_seen_n = xtal_seen;
    cal_n       = 1'b0;
    por_n       = por & ~rd_done;
    if (wr_en) begin
      case (wr_sub)
        SUB_XTAL: begin
          r0_n        = ctl0_t'(wr_data);
          xtal_seen_n = 1'b1;
        end
        SUB_CAL: begin
          r1_n  = ctl1_t'(wr_data);
          cal_n = xtal_seen;
        end
        SUB_VID:  r2_n = ctl2_t'(wr_data);
        SUB_MODE: r3_n = wr_data[7];
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0        <= '0;
      r1        <= '0;
      r2        <= '0;
      r3_llc    <= 1'b0;
      xtal_seen <= 1'b0;
      cal_req   <= 1'b0;
      por       <= 1'b1;
    end else begin
      r0        <= r0_n;
      r1        <= r1_n;
      r2        <= r2_n;
      r3_llc    <= r3_n;
      xtal_seen <= xtal_seen_n;
      cal_req   <= cal_n;
      por       <= por_n;
    end
  end

  assign status_byte = {por, live_status};

  assert_cal_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |-> $past(wr_en && wr_sub == SUB_CAL));

  assert_por_clears_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por) |-> $past(rd_done));

  assert_unimpl_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sub > LAST_IMPL) |=>
      ($stable(r0) && $stable(r1) && $stable(r2) && $stable(r3_llc)));

endmodule

// File: rtl/vdec_ctl_i2c.sv
module vdec_ctl_i2c
  import vdec_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_strap,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_low,
  output logic [1:0] src_sel,
  output logic       trap_bypass,
  output logic       comb_en,
  output logic [1:0] p1_tc_sel,
  output logic [1:0] xtal_cfg,
  output logic [1:0] field_force,
  output logic       ioport_out,
  output logic       oport_out,
  output logic       p1_open,
  output logic       std_force,
  output logic       secam_force,
  output logic       xtal_force,
  output logic       fsw_en,
  output logic       search_tune,
  output logic [5:0] hue,
  output logic       llc_mode,
  output logic       cal_req,
  input  logic       fld60_in,
  input  logic       yc_in,
  input  logic       p1_lock_in,
  input  logic       ioport_pin_in,
  input  logic [2:0] std_code_in
);

  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en, rd_done;
  logic [SUB_W-1:0] wr_sub;
  logic [7:0]       wr_data, status_byte;
  ctl0_t            r0;
  ctl1_t            r1;
  ctl2_t            r2;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  vdec_i2c_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  vdec_i2c_engine engine_i (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .strap         (addr_strap),
    .scl_lvl       (scl_lvl),
    .sda_lvl       (sda_lvl),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .status_byte   (status_byte),
    .sda_drive_low (sda_pull_low),
    .wr_en         (wr_en),
    .wr_sub        (wr_sub),
    .wr_data       (wr_data),
    .rd_done       (rd_done)
  );

  vdec_regbank regs_i (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .wr_en       (wr_en),
    .wr_sub      (wr_sub),
    .wr_data     (wr_data),
    .rd_done     (rd_done),
    .live_status ({fld60_in, yc_in, p1_lock_in, ioport_pin_in, std_code_in}),
    .r0          (r0),
    .r1          (r1),
    .r2          (r2),
    .r3_llc      (llc_mode),
    .cal_req     (cal_req),
    .status_byte (status_byte)
  );

  assign src_sel     = r0.src;
  assign trap_bypass = r0.trap;
  assign comb_en     = r0.comb;
  assign p1_tc_sel   = r0.tc;
  assign xtal_cfg    = r0.xtal;
  assign field_force = r1.fforce;
  assign ioport_out  = r1.iop;
  assign oport_out   = r1.op;
  assign p1_open     = r1.open;
  assign std_force   = r1.stdf;
  assign secam_force = r1.secam;
  assign xtal_force  = r1.xforce;
  assign fsw_en      = r2.fsw;
  assign search_tune = r2.stm;
  assign hue         = r2.hue;

endmodule

// File: tb/vdec_ctl_i2c_tb.sv
module vdec_ctl_i2c_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_strap = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_pull_low;
  logic [1:0] src_sel, p1_tc_sel, xtal_cfg, field_force;
  logic       trap_bypass, comb_en, ioport_out, oport_out, p1_open;
  logic       std_force, secam_force, xtal_force, fsw_en, search_tune, llc_mode, cal_req;
  logic [5:0] hue;
  logic       fld60_in = 1'b0, yc_in = 1'b0, p1_lock_in = 1'b0, ioport_pin_in = 1'b0;
  logic [2:0] std_code_in = 3'b000;

  int vectors = 0;
  int fails   = 0;
  int cal_cnt = 0;
  int r12_bad = 0;
  logic prev_pull = 1'b0;

  assign sda_line = sda_m & ~sda_pull_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  vdec_ctl_i2c dut_i (
    .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap),
    .scl_i(scl), .sda_i(sda_line), .sda_pull_low(sda_pull_low),
    .src_sel(src_sel), .trap_bypass(trap_bypass), .comb_en(comb_en),
    .p1_tc_sel(p1_tc_sel), .xtal_cfg(xtal_cfg), .field_force(field_force),
    .ioport_out(ioport_out), .oport_out(oport_out), .p1_open(p1_open),
    .std_force(std_force), .secam_force(secam_force), .xtal_force(xtal_force),
    .fsw_en(fsw_en), .search_tune(search_tune), .hue(hue), .llc_mode(llc_mode),
    .cal_req(cal_req), .fld60_in(fld60_in), .yc_in(yc_in), .p1_lock_in(p1_lock_in),
    .ioport_pin_in(ioport_pin_in), .std_code_in(std_code_in)
  );

  always @(negedge clk) begin
    if (cal_req) cal_cnt++;
    if (sda_pull_low && !prev_pull && scl) r12_bad++;
    prev_pull = sda_pull_low;
  end

  function automatic logic [23:0] outs();
    return {src_sel, trap_bypass, comb_en, p1_tc_sel, xtal_cfg,
            field_force, ioport_out, oport_out, p1_open, std_force, secam_force, xtal_force,
            fsw_en, search_tune, hue};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq();
    scl = 1'b1; wq();
    sda_m = 1'b1; wq(); wq();
  endtask

  task automatic i2c_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl = 1'b1; wq(); wq();
      scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    ack = ~sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic i2c_rbyte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl = 1'b1; wq();
      b[i] = sda_line; wq();
      scl = 1'b0; wq();
    end
    sda_m = ~give_ack; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic wr_one(input logic [7:0] sub, input logic [7:0] d);
    logic a0, a1, a2;
    i2c_start();
    i2c_wbyte(8'h8A, a0);
    i2c_wbyte(sub, a1);
    i2c_wbyte(d, a2);
    i2c_stop();
    check("R1/R2 ack write", {a0, a1, a2}, 3'b111);
  endtask

  task automatic t_reset();
    check("R11 outputs after reset", {outs(), llc_mode, cal_req}, 26'h0);
    check("R11 sda released", sda_pull_low, 1'b0);
  endtask

  task automatic t_address();
    logic a, b;
    addr_strap = 1'b0;
    i2c_start(); i2c_wbyte(8'h8E, a); i2c_wbyte(8'h00, b); i2c_stop();
    check("R1 strap low rejects 8E", {a, b}, 2'b00);
    i2c_start(); i2c_wbyte(8'h8A, a); i2c_stop();
    check("R1 strap low accepts 8A", a, 1'b1);
    addr_strap = 1'b1; wq();
    i2c_start(); i2c_wbyte(8'h8E, a); i2c_stop();
    check("R1 strap high accepts 8E", a, 1'b1);
    i2c_start(); i2c_wbyte(8'h8A, a); i2c_stop();
    check("R1 strap high rejects 8A", a, 1'b0);
    addr_strap = 1'b0; wq();
  endtask

  task automatic t_cal_order();
    wr_one(8'h01, 8'h00);
    check("R10 no calibration before crystal write", cal_cnt, 0);
    wr_one(8'h00, 8'h00);
    check("R10 crystal write alone no calibration", cal_cnt, 0);
    wr_one(8'h01, 8'h00);
    check("R10 calibration after ordered writes", cal_cnt, 1);
  endtask

  task automatic t_fields();
    logic [7:0] d [4];
    logic a;
    d[0] = 8'hB6; d[1] = 8'h5D; d[2] = 8'hA9; d[3] = 8'hFF;
    i2c_start(); i2c_wbyte(8'h8A, a); i2c_wbyte(8'h00, a);
    for (int k = 0; k < 4; k++) i2c_wbyte(d[k], a);
    i2c_stop();
    check("R3 reg0 fields", {src_sel, trap_bypass, comb_en, p1_tc_sel, xtal_cfg},
          {d[0][7:6], d[0][5], d[0][4], d[0][3:2], d[0][1:0]});
    check("R4 reg1 fields", {field_force, ioport_out, oport_out, p1_open, std_force,
          secam_force, xtal_force}, {d[1][7:6], d[1][5], d[1][4], d[1][3], d[1][2], d[1][1], d[1][0]});
    check("R5 reg2 fields", {fsw_en, search_tune, hue}, {d[2][7], d[2][6], d[2][5:0]});
    check("R5 reg3 llc_mode", llc_mode, d[3][7]);
    check("R10 burst calibration count", cal_cnt, 2);
    wr_one(8'h03, 8'h7F);
    check("R5 reg3 low bits ignored", llc_mode, 1'b0);
  endtask

  task automatic t_wrap();
    logic a;
    logic [5:0] hue_before;
    hue_before = hue;
    i2c_start(); i2c_wbyte(8'h8A, a); i2c_wbyte(8'h0F, a);
    i2c_wbyte(8'h11, a); i2c_wbyte(8'h44, a); i2c_stop();
    check("R2 wrap 0F to 00", {src_sel, trap_bypass, comb_en, p1_tc_sel, xtal_cfg}, 8'h44);
    check("R2 no spill into reg2", hue, hue_before);
  endtask

  task automatic t_unimpl();
    logic [24:0] snap;
    logic a0, a1, a2, a3;
    snap = {outs(), llc_mode};
    i2c_start(); i2c_wbyte(8'h8A, a0); i2c_wbyte(8'h05, a1);
    i2c_wbyte(8'hFF, a2); i2c_wbyte(8'h00, a3); i2c_stop();
    check("R6 unimplemented acked", {a0, a1, a2, a3}, 4'b1111);
    check("R6 outputs unchanged", {outs(), llc_mode}, snap);
  endtask

  task automatic t_status();
    logic a;
    logic [7:0] b0, b1;
    fld60_in = 1'b1; yc_in = 1'b0; p1_lock_in = 1'b1; ioport_pin_in = 1'b1; std_code_in = 3'b011;
    wq();
    i2c_start(); i2c_wbyte(8'h8B, a); i2c_rbyte(1'b0, b0); i2c_stop();
    check("R7/R8 first status read with power-on flag", {a, b0}, {1'b1, 8'hDB});
    std_code_in = 3'b110; yc_in = 1'b1; wq();
    i2c_start(); i2c_wbyte(8'h8B, a); i2c_rbyte(1'b1, b0); i2c_rbyte(1'b0, b1); i2c_stop();
    check("R8 power-on flag cleared", b0, 8'h7E);
    check("R9 repeated read returns status", b1, b0);
    check("R9 released after nack", sda_pull_low, 1'b0);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_address();
    t_cal_order();
    t_fields();
    t_wrap();
    t_unimpl();
    t_status();
    check("R12 pull only while SCL low", r12_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule